// File: doc/BRIEF.md
# Two-Wire Register Slave with Strapped Address

This block is the serial front end of a small register-mapped peripheral. A fast system clock oversamples the clock and data lines of a two-wire (I2C) bus. The block answers at one of two 7-bit addresses, picked by a strap input. It turns bus writes and reads into one-cycle register strobes that carry an address and a data byte. The data line is open-drain: the block only ever pulls it low, through `sda_oe`.

A write transfer works like this. The first byte after the address loads an internal register pointer. Each later byte issues a write strobe at the pointer, and the pointer then steps by one. A read transfer returns the byte at the pointer and then steps the pointer. It keeps sending bytes while the master acknowledges, and it stops at a master NACK. General-call commands are decoded selectively:
- One command clears the pointer and pulses a reset output for the register file.
- One command only re-samples the strap.
- Every other command is refused.

Writing a shutdown request into the register file stops the block after the ACK of that byte. The block holds that ACK for a fixed window, then releases the line and ignores the bus until `rst_n` is asserted.

The states are: `ST_IDLE` (waiting for START), `ST_ADDR` (shifting the address byte), `ST_RECV` (shifting a written byte), `ST_ACK` (pulling SDA low for the acknowledge), `ST_SEND` (driving read data), `ST_MACK` (sampling the master's acknowledge), `ST_HOLD` (holding the final ACK before shutdown) and `ST_DEAD` (off). The transitions are:
- START moves any state except HOLD and DEAD to ADDR.
- STOP moves those same states to IDLE.
- From ADDR, a completed byte goes to ACK when it matches, and to IDLE when it does not.
- From RECV, an accepted byte goes to ACK, and a refused byte goes to IDLE.
- From ACK, the falling SCL edge goes to SEND for a read and to RECV for a write. If a shutdown request is pending at the rising SCL edge, ACK goes to HOLD instead.
- From SEND, a completed byte goes to MACK.
- From MACK, the falling SCL edge goes to SEND if the master acknowledged, and to IDLE if it did not.
- HOLD goes to DEAD when its window runs out.
- IDLE goes to DEAD when a shutdown request is present.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset, `sda_oe`, `reg_wr`, `reg_rd`, `gc_reset` and `shut` are all 0.
- R2: At each START the block samples `addr_sel`. It then answers address 0x41 when the strap is 0 and address 0x44 when the strap is 1. The R/W bit is bit 0 of the first byte, with 1 meaning read. So the write/read bytes are 0x82/0x83 and 0x88/0x89. It NACKs any other address, and no strobe follows.
- R3: In a write transfer, the first data byte loads the pointer. Each later byte produces one `reg_wr` pulse with `reg_addr` = pointer and `reg_wdata` = byte, and the pointer then steps by 1. Every such byte is ACKed.
- R4: In a read transfer, each byte is taken from `reg_rdata` while `reg_rd` pulses with `reg_addr` = pointer, and the pointer steps by 1. Bytes are sent MSB first. The transfer continues while the master ACKs and ends when the master NACKs.
- R5: The general-call address byte 0x00 is ACKed. A second byte of 0x06 is ACKed, pulses `gc_reset` for one cycle and clears the pointer to 0.
- R6: A general-call second byte of 0x04 is ACKed, re-samples the strap and leaves the pointer and `gc_reset` untouched. Any other second byte, including 0x00, is NACKed and has no effect.
- R7: If `shdn_req` is high when SCL rises in an ACK slot, SDA stays pulled low for `HOLD_CYC` cycles. The block then releases SDA and sets `shut`. From then on it NACKs and ignores all traffic until `rst_n` is asserted.
- R8: The block works at both 100 kHz and 400 kHz SCL with a 100 MHz system clock.
- R9: A repeated START inside a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel | input | 1 | Address strap (0 selects 0x41, 1 selects 0x44) |
| shdn_req | input | 1 | Shutdown request bit from the register file |
| reg_rdata | input | 8 | Register file data at `reg_addr` |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to write |
| gc_reset | output | 1 | One-cycle reset pulse from a general call |
| shut | output | 1 | Block is shut down |

## Verification
The assertions check four things on every cycle:
- After each write or read strobe, the pointer has stepped by exactly one.
- A general-call reset leaves the pointer at zero.
- Once `shut` rises, it stays high and no strobe follows.
- Shutdown is entered only from the hold window or from idle.

The rest can only be shown by the bench's bus scenarios:
- whether a given address is acknowledged for each strap value;
- that read data arrives in order and the read ends correctly on a master NACK;
- which general-call codes are refused;
- how long the final ACK is held;
- that the block comes back after a hard reset;
- that it runs at both bus speeds.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_RECV, ST_ACK, ST_SEND, ST_MACK, ST_HOLD, ST_DEAD
    } ss_state_e;

    localparam logic [7:0] GC_CMD_RESET = 8'h06;
    localparam logic [7:0] GC_CMD_LATCH = 8'h04;
    localparam int         BIT_CNT_W    = 4;
endpackage

// File: rtl/i2c_ss_sync.sv
module i2c_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign q    = chain[STAGES-1];
    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/i2c_ss_cond.sv
module i2c_ss_cond (
    input  logic scl_q,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start,
    output logic stop
);
    assign start = scl_q & sda_fall;
    assign stop  = scl_q & sda_rise;
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
    import i2c_ss_pkg::*;
#(
    parameter int         HOLD_CYC    = 25000,
    parameter logic [6:0] ADDR_LO     = 7'h41,
    parameter logic [6:0] ADDR_HI     = 7'h44,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel,
    input  logic       shdn_req,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       gc_reset,
    output logic       shut
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [1:0] line_in, line_q, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            i2c_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(line_in[g]),
                .q(line_q[g]), .rise(line_rise[g]), .fall(line_fall[g])
            );
        end
    endgenerate

    logic scl_q, sda_q, scl_rise, scl_fall, start, stop;
    assign scl_q    = line_q[0];
    assign sda_q    = line_q[1];
    assign scl_rise = line_rise[0];
    assign scl_fall = line_fall[0];

    i2c_ss_cond u_cond (
        .scl_q(scl_q), .sda_rise(line_rise[1]), .sda_fall(line_fall[1]),
        .start(start), .stop(stop)
    );

    ss_state_e              state, state_nx;
    logic [BIT_CNT_W-1:0]   bit_cnt;
    logic [7:0]             shreg, ptr;
    logic [6:0]             my_addr;
    logic                   rw, gc, ptr_phase, mack;
    logic [HOLD_W-1:0]      hold_cnt;
    logic                   byte_done, live, addr_hit, gc_hit, rx_ok;

    assign byte_done = scl_fall && (bit_cnt == BIT_CNT_W'(8));
    assign live      = (state != ST_HOLD) && (state != ST_DEAD);
    assign addr_hit  = (shreg[7:1] == my_addr);
    assign gc_hit    = (shreg == 8'h00);
    assign rx_ok     = !gc || (shreg == GC_CMD_RESET) || (shreg == GC_CMD_LATCH);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (live && start)     state_nx = ST_ADDR;
        else if (live && stop) state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE: if (shdn_req) state_nx = ST_DEAD;
                ST_ADDR: if (byte_done) state_nx = (addr_hit || gc_hit) ? ST_ACK : ST_IDLE;
                ST_RECV: if (byte_done) state_nx = rx_ok ? ST_ACK : ST_IDLE;
                ST_ACK: begin
                    if (scl_rise && shdn_req) state_nx = ST_HOLD;
                    else if (scl_fall)        state_nx = rw ? ST_SEND : ST_RECV;
                end
                ST_SEND: if (byte_done) state_nx = ST_MACK;
                ST_MACK: if (scl_fall) state_nx = mack ? ST_SEND : ST_IDLE;
                ST_HOLD: if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) state_nx = ST_DEAD;
                ST_DEAD: state_nx = ST_DEAD;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;  bit_cnt <= '0;  shreg <= '0;  ptr <= '0;
            my_addr <= ADDR_LO; rw <= 1'b0;  gc <= 1'b0;  ptr_phase <= 1'b0;
            mack <= 1'b0;      hold_cnt <= '0;
        end else begin
            state    <= state_nx;
            hold_cnt <= (state == ST_HOLD) ? hold_cnt + HOLD_W'(1) : '0;
            if (live && start) begin
                bit_cnt <= '0;
                gc      <= 1'b0;
                my_addr <= addr_sel ? ADDR_HI : ADDR_LO;
            end else begin
                if ((state == ST_ADDR || state == ST_RECV) && scl_rise) begin
                    shreg   <= {shreg[6:0], sda_q};
                    bit_cnt <= bit_cnt + BIT_CNT_W'(1);
                end
                if (state == ST_SEND) begin
                    if (scl_rise) bit_cnt <= bit_cnt + BIT_CNT_W'(1);
                    if (scl_fall && !byte_done) shreg <= {shreg[6:0], 1'b1};
                end
                if (byte_done) bit_cnt <= '0;
                if (state == ST_ADDR && byte_done) begin
                    rw        <= shreg[0];
                    gc        <= gc_hit;
                    ptr_phase <= !shreg[0];
                end
                if (state == ST_RECV && byte_done && rx_ok) begin
                    if (gc) begin
                        my_addr <= addr_sel ? ADDR_HI : ADDR_LO;
                        if (shreg == GC_CMD_RESET) ptr <= '0;
                    end else if (ptr_phase) begin
                        ptr       <= shreg;
                        ptr_phase <= 1'b0;
                    end else begin
                        ptr <= ptr + 8'd1;
                    end
                end
                if (state == ST_MACK && scl_rise) mack <= ~sda_q;
                if (reg_rd) begin
                    shreg   <= reg_rdata;
                    ptr     <= ptr + 8'd1;
                    bit_cnt <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = (state == ST_ACK) || (state == ST_HOLD) ||
                    (state == ST_SEND && !shreg[7]);
        shut      = (state == ST_DEAD);
        reg_wr    = (state == ST_RECV) && byte_done && !gc && !ptr_phase && !start;
        gc_reset  = (state == ST_RECV) && byte_done && gc && (shreg == GC_CMD_RESET) && !start;
        reg_rd    = scl_fall && rw && !start &&
                    (((state == ST_ACK) && !(scl_rise && shdn_req)) ||
                     ((state == ST_MACK) && mack));
        reg_addr  = ptr;
        reg_wdata = shreg;
    end

    // R3
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_addr == 8'($past(reg_addr) + 8'd1));
    // R4
    rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_addr == 8'($past(reg_addr) + 8'd1));
    // R5
    gc_ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> reg_addr == 8'd0);
    // R7
    dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> shut);
    // R7
    dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut) |-> ($past(state) == ST_HOLD || $past(state) == ST_IDLE));
    // R7
    dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut |-> !(reg_wr || reg_rd || gc_reset || sda_oe));
endmodule

// File: tb/i2c_strap_slave_tb.sv
module i2c_strap_slave_tb;
    localparam int HOLD = 400;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
    logic sda_oe, reg_wr, reg_rd, gc_reset, shut, shdn_q;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [256];
    wire  sda = m_sda & ~sda_oe;
    int   q_cyc = 63, n_chk = 0, n_fail = 0, gc_cnt = 0;
    bit   done = 1'b0;
    logic [15:0] exp_q [$];

    always #5 clk = ~clk;

    i2c_strap_slave #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda), .addr_sel(addr_sel),
        .shdn_req(shdn_q), .reg_rdata(reg_rdata), .sda_oe(sda_oe), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .gc_reset(gc_reset), .shut(shut));

    assign reg_rdata = mem[reg_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // register-file model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) shdn_q <= 1'b0;
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            if (reg_addr == 8'h05) shdn_q <= reg_wdata[1];
            if (exp_q.size() == 0) check(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R3 write strobe", {reg_addr, reg_wdata}, e);
            end
        end
        if (gc_reset) gc_cnt++;
    end

    task automatic wait_q(); repeat (q_cyc) @(negedge clk); endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q(); m_sda = 1'b1; wait_q();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; wait_q(); m_scl = 1'b1; wait_q(); s = sda; wait_q(); m_scl = 1'b0; wait_q();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q(); ack = ~sda; wait_q(); m_scl = 1'b0;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        wait_q();
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(~give_ack, s);
    endtask

    task automatic expect_ack(input logic [7:0] b, input logic exp, input string tag);
        logic a;
        wbyte(b, a);
        wait_q();
        check(a == exp, tag, a, exp);
    endtask

    task automatic read_expect(input logic [7:0] rd_addr, input int n, input logic [7:0] base);
        logic [7:0] v;
        i2c_start();
        expect_ack(rd_addr, 1'b1, "R4 read address ack");
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, v);
            check(v == mem[8'(base + i)], "R4 read data", v, mem[8'(base + i)]);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int g0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
        repeat (5) @(negedge clk);
        check({sda_oe, reg_wr, reg_rd, gc_reset, shut} == 5'b0, "R1 reset outputs",
              {sda_oe, reg_wr, reg_rd, gc_reset, shut}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({sda_oe, shut} == 2'b0, "R1 idle after reset", {sda_oe, shut}, 0);

        // R2 / R3: write burst at 0x41
        exp_q.push_back(16'h10A1); exp_q.push_back(16'h11A2); exp_q.push_back(16'h12A3);
        i2c_start();
        expect_ack(8'h82, 1'b1, "R2 addr 0x41 write");
        expect_ack(8'h10, 1'b1, "R3 pointer byte ack");
        expect_ack(8'hA1, 1'b1, "R3 data ack");
        expect_ack(8'hA2, 1'b1, "R3 data ack");
        expect_ack(8'hA3, 1'b1, "R3 data ack");
        i2c_stop();

        // R9 / R4: pointer write, repeated start, read burst
        i2c_start();
        expect_ack(8'h82, 1'b1, "R9 addr ack");
        expect_ack(8'h10, 1'b1, "R9 pointer ack");
        read_expect(8'h83, 3, 8'h10);
        read_expect(8'h83, 1, 8'h13);

        // R2: strap selection sampled per START
        i2c_start(); expect_ack(8'h88, 1'b0, "R2 0x44 refused with strap 0"); i2c_stop();
        addr_sel = 1'b1;
        i2c_start(); expect_ack(8'h82, 1'b0, "R2 0x41 refused with strap 1"); i2c_stop();
        exp_q.push_back(16'h203C);
        i2c_start();
        expect_ack(8'h88, 1'b1, "R2 0x44 with strap 1");
        expect_ack(8'h20, 1'b1, "R3 pointer ack");
        expect_ack(8'h3C, 1'b1, "R3 data ack");
        i2c_stop();
        check(exp_q.size() == 0, "R3 write count", exp_q.size(), 0);

        // R8: standard-mode rate
        q_cyc = 250;
        exp_q.push_back(16'h3077);
        i2c_start();
        expect_ack(8'h88, 1'b1, "R8 slow addr");
        expect_ack(8'h30, 1'b1, "R8 slow pointer");
        expect_ack(8'h77, 1'b1, "R8 slow data");
        i2c_start();
        expect_ack(8'h88, 1'b1, "R8 slow addr 2");
        expect_ack(8'h30, 1'b1, "R8 slow pointer 2");
        read_expect(8'h89, 1, 8'h30);
        q_cyc = 63;

        // R5: general-call reset
        g0 = gc_cnt;
        i2c_start();
        expect_ack(8'h00, 1'b1, "R5 general call ack");
        expect_ack(8'h06, 1'b1, "R5 reset code ack");
        i2c_stop();
        check(gc_cnt == g0 + 1, "R5 gc_reset pulse", gc_cnt, g0 + 1);
        read_expect(8'h89, 1, 8'h00);

        // R6: latch code and refused codes
        i2c_start();
        expect_ack(8'h00, 1'b1, "R6 general call ack");
        expect_ack(8'h04, 1'b1, "R6 latch code ack");
        i2c_stop();
        i2c_start();
        expect_ack(8'h00, 1'b1, "R6 general call ack");
        expect_ack(8'h00, 1'b0, "R6 code 0x00 refused");
        i2c_stop();
        i2c_start();
        expect_ack(8'h00, 1'b1, "R6 general call ack");
        expect_ack(8'h07, 1'b0, "R6 code 0x07 refused");
        i2c_stop();
        check(gc_cnt == g0 + 1, "R6 no extra gc_reset", gc_cnt, g0 + 1);
        read_expect(8'h89, 1, 8'h01);

        // R7: shutdown
        exp_q.push_back(16'h0502);
        i2c_start();
        expect_ack(8'h88, 1'b1, "R7 addr");
        expect_ack(8'h05, 1'b1, "R7 pointer");
        begin
            logic a;
            wbyte(8'h02, a);
            check(a == 1'b1, "R7 shutdown byte acked", a, 1);
            check(sda_oe == 1'b1, "R7 ack held in window", sda_oe, 1);
        end
        repeat (HOLD + 20) @(negedge clk);
        check(sda_oe == 1'b0, "R7 line released", sda_oe, 0);
        check(shut == 1'b1, "R7 shut set", shut, 1);
        i2c_stop();
        i2c_start(); expect_ack(8'h88, 1'b0, "R7 traffic ignored"); i2c_stop();
        check(shut == 1'b1, "R7 stays shut", shut, 1);
        rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
        check(shut == 1'b0, "R7 revived by reset", shut, 0);
        i2c_start(); expect_ack(8'h88, 1'b1, "R7 answers after reset"); i2c_stop();
        check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule